// File: doc/BRIEF.md
# Configuration Clock Pulse Generator

This block produces a software-requested number of pulses on a configuration clock output and reports when the last pulse has finished. A host writes a pulse count into a count register over a simple single-cycle register port. The block then drives the clock output high for a fixed number of system clocks and low for the same number, once per requested pulse. While it does this, the count register reads back how many pulses are still to come.

Completion is latched in a sticky status bit that software clears by writing a 1 to it. A new count is accepted only while that bit is clear, so a stale completion can never be confused with a fresh one. A typical use is a short burst of four pulses, issued once configuration data has been sent, to step the configured device into its operating mode.

Top module: `cfgclk_pulse_gen`

## Requirements
- R1: After reset the clock output is low, the count register (byte offset 0x8) reads 0 and the status register (byte offset 0xC) reads 0.
- R2: A write of N > 0 to offset 0x8 while the done bit is clear produces exactly N pulses on the clock output.
- R3: Every pulse is high for HALF_CYC system clocks and then low for HALF_CYC system clocks. The first high phase starts in the cycle after the write, and the output stays low while no burst runs.
- R4: The done bit (status bit 0) sets at the clock edge that ends the low phase of the last pulse, and not earlier. At that point the count register reads 0.
- R5: Writing offset 0xC with bit 0 = 1 clears the done bit. Writing it with bit 0 = 0 leaves the bit unchanged.
- R6: A count write while the done bit is set is ignored: no pulses follow, the count register keeps its value and done stays set.
- R7: A count write of 0 while done is clear produces no pulse and sets done in the following cycle.
- R8: The count register reads the number of pulses still owed. It decrements by one at the end of each pulse's low phase.
- R9: A count write of N > 0 during a burst reloads the counter with N and restarts at a high phase without setting done. Exactly N further pulses follow.
- R10: If a count write lands in the same cycle that the last pulse ends, the reload wins: done stays clear and the new burst runs.
- R11: Writes to any other offset have no effect, and reads of any other offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr, combinational |
| dclk_o | output | 1 | Configuration clock pulse output |

## Verification
Two events can fall in the same cycle: the end of a burst's final low phase and a new count write. The bench provokes this by writing a one-pulse burst and then timing a second count write so that the write is sampled on exactly the edge that would set done. It judges the result by the status bit staying 0, the count register holding the new value, and the scoreboard counting the old pulse plus the new ones before done finally sets at the recomputed edge. A reload in mid-burst, issued during a low phase, is judged the same way.

// File: rtl/cpg_pkg.sv
package cpg_pkg;

    // Register selected by a host access
    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_COUNT  = 2'd1,
        SEL_STATUS = 2'd2
    } cpg_sel_e;

    // Byte offsets of the two registers
    localparam int unsigned CPG_COUNT_OFS  = 8;
    localparam int unsigned CPG_STATUS_OFS = 12;

endpackage

// File: rtl/cpg_regif.sv
module cpg_regif
    import cpg_pkg::*;
#(
    parameter int unsigned ADDR_W     = 4,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned COUNT_OFS  = CPG_COUNT_OFS,
    parameter int unsigned STATUS_OFS = CPG_STATUS_OFS
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] remaining,
    input  logic              done,
    output logic              load_req,
    output logic              clr_req,
    output logic [DATA_W-1:0] load_val,
    output logic [DATA_W-1:0] rdata
);

    cpg_sel_e sel;

    always_comb begin
        if (addr == ADDR_W'(COUNT_OFS)) begin
            sel = SEL_COUNT;
        end else if (addr == ADDR_W'(STATUS_OFS)) begin
            sel = SEL_STATUS;
        end else begin
            sel = SEL_NONE;
        end
    end

    always_comb begin
        load_req = wr_en && (sel == SEL_COUNT);
        clr_req  = wr_en && (sel == SEL_STATUS) && wdata[0];
        load_val = wdata;
        case (sel)
            SEL_COUNT:  rdata = remaining;
            SEL_STATUS: rdata = {{(DATA_W-1){1'b0}}, done};
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/cpg_phase_timer.sv
module cpg_phase_timer #(
    parameter int unsigned HALF_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic phase_end
);

    localparam int unsigned TMR_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [TMR_W-1:0] LAST = TMR_W'(HALF_CYC - 1);

    typedef struct packed {
        logic [TMR_W-1:0] tmr;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        phase_end = 1'b0;
        if (restart) begin
            st_d.tmr = '0;
        end else if (run) begin
            if (st_q.tmr == LAST) begin
                phase_end = 1'b1;
                st_d.tmr  = '0;
            end else begin
                st_d.tmr = st_q.tmr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    generate
        if (HALF_CYC > 1) begin : g_restart_chk
            AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
                restart |=> !phase_end) else $error("phase restart"); // R3
        end
    endgenerate

endmodule

// File: rtl/cpg_burst_ctrl.sv
module cpg_burst_ctrl #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_req,
    input  logic [CNT_W-1:0] load_val,
    input  logic             clr_req,
    input  logic             phase_end,
    output logic             restart,
    output logic             active,
    output logic             dclk,
    output logic [CNT_W-1:0] remaining,
    output logic             done
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic             active;
        logic             dclk;
        logic             done;
        logic [CNT_W-1:0] rem;
    } burst_state_t;

    burst_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        restart = 1'b0;
        if (load_req && !st_q.done) begin
            // accepted count write; takes priority over the phase step
            restart = 1'b1;
            if (load_val == '0) begin
                st_d.active = 1'b0;
                st_d.dclk   = 1'b0;
                st_d.rem    = '0;
                st_d.done   = 1'b1;
            end else begin
                st_d.active = 1'b1;
                st_d.dclk   = 1'b1;
                st_d.rem    = load_val;
            end
        end else begin
            if (clr_req) begin
                st_d.done = 1'b0;
            end
            if (st_q.active && phase_end) begin
                if (st_q.dclk) begin
                    st_d.dclk = 1'b0;
                end else if (st_q.rem == ONE) begin
                    st_d.active = 1'b0;
                    st_d.rem    = '0;
                    st_d.done   = 1'b1;
                end else begin
                    st_d.rem  = st_q.rem - ONE;
                    st_d.dclk = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active    = st_q.active;
    assign dclk      = st_q.dclk;
    assign remaining = st_q.rem;
    assign done      = st_q.done;

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.active |-> !st_q.dclk) else $error("idle high"); // R3
    AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> !st_q.active) else $error("done while active"); // R4
    AST_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && phase_end && !st_q.dclk && st_q.rem == ONE && !load_req)
        |=> (st_q.done && !st_q.active && st_q.rem == '0)) else $error("finish"); // R4
    AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !load_req && !st_q.active) |=> !st_q.done) else $error("w1c"); // R5
    AST_STALE: assert property (@(posedge clk) disable iff (!rst_n)
        (load_req && st_q.done) |=> (st_q.done && !st_q.active && $stable(st_q.rem)))
        else $error("stale load"); // R6
    AST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (load_req && !st_q.done && load_val == '0) |=> (st_q.done && !st_q.active))
        else $error("zero load"); // R7
    AST_REM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && !phase_end && !load_req) |=> $stable(st_q.rem))
        else $error("rem moved"); // R8
    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (load_req && !st_q.done && load_val != '0)
        |=> (st_q.active && st_q.dclk && !st_q.done && st_q.rem == $past(load_val)))
        else $error("reload"); // R9 R10

endmodule

// File: rtl/cfgclk_pulse_gen.sv
module cfgclk_pulse_gen
    import cpg_pkg::*;
#(
    parameter int unsigned ADDR_W     = 4,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned HALF_CYC   = 4,
    parameter int unsigned COUNT_OFS  = CPG_COUNT_OFS,
    parameter int unsigned STATUS_OFS = CPG_STATUS_OFS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              dclk_o
);

    logic              load_req;
    logic              clr_req;
    logic [DATA_W-1:0] load_val;
    logic [DATA_W-1:0] remaining;
    logic              done;
    logic              active;
    logic              restart;
    logic              phase_end;

    cpg_regif #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .COUNT_OFS (COUNT_OFS),
        .STATUS_OFS(STATUS_OFS)
    ) i_regif (
        .wr_en    (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .remaining(remaining),
        .done     (done),
        .load_req (load_req),
        .clr_req  (clr_req),
        .load_val (load_val),
        .rdata    (reg_rdata)
    );

    cpg_phase_timer #(
        .HALF_CYC(HALF_CYC)
    ) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (active),
        .restart  (restart),
        .phase_end(phase_end)
    );

    cpg_burst_ctrl #(
        .CNT_W(DATA_W)
    ) i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_req (load_req),
        .load_val (load_val),
        .clr_req  (clr_req),
        .phase_end(phase_end),
        .restart  (restart),
        .active   (active),
        .dclk     (dclk_o),
        .remaining(remaining),
        .done     (done)
    );

    AST_OTHER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr != ADDR_W'(COUNT_OFS) && reg_addr != ADDR_W'(STATUS_OFS))
        |-> (reg_rdata == '0)) else $error("other addr read"); // R11

endmodule

// File: tb/test_cfgclk_pulse_gen.sv
module test_cfgclk_pulse_gen;

    localparam int HALF = 4;
    localparam int PER  = 2 * HALF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dclk_o;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    int exp_q[$];
    int mon_rises = 0;
    int mon_high = 0;
    bit mon_prev = 0;
    bit close_req = 0;
    string close_tag;

    always #10 clk = ~clk;

    cfgclk_pulse_gen #(.HALF_CYC(HALF)) i_cfgclk_pulse_gen (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dclk_o(dclk_o)
    );

    task automatic check_eq(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: counts pulses, checks high width, pops expected counts
    always @(negedge clk) begin
        if (rst_n) begin
            if (dclk_o && !mon_prev) begin
                mon_rises++;
                mon_high = 1;
            end else if (dclk_o) begin
                mon_high++;
            end else if (mon_prev) begin
                check_eq("R3 high width", mon_high, HALF);
            end
            mon_prev = dclk_o;
            if (close_req) begin
                if (exp_q.size() == 0) begin
                    check_eq({close_tag, " queue empty"}, 1, 0);
                end else begin
                    check_eq({close_tag, " pulse count"}, mon_rises, exp_q.pop_front());
                end
                mon_rises = 0;
                close_req = 0;
            end
        end
    end

    task automatic push_exp(int n);
        exp_q.push_back(n);
    endtask

    task automatic close_burst(string tag);
        close_tag = tag;
        close_req = 1;
        wait (close_req == 0);
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] v);
        reg_wr = 1'b1;
        reg_addr = a;
        reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic edges(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_reg(string tag, logic [3:0] a, longint exp);
        logic [31:0] v;
        rd(a, v);
        check_eq(tag, v, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        edges(3);
        rst_n = 1'b1;
        edges(1);

        // R1 reset state
        check_eq("R1 dclk", dclk_o, 0);
        expect_reg("R1 count", 4'h8, 0);
        expect_reg("R1 status", 4'hC, 0);

        // R2 R4 four-pulse burst
        push_exp(4);
        wr(4'h8, 4);
        edges(4 * PER - 1);
        expect_reg("R4 not early", 4'hC, 0);
        edges(1);
        expect_reg("R4 done set", 4'hC, 1);
        expect_reg("R4 count zero", 4'h8, 0);
        close_burst("R2 burst4");

        // R5 clear behaviour
        wr(4'hC, 32'h2);
        expect_reg("R5 bit0 zero keeps done", 4'hC, 1);

        // R6 stale done blocks a count write
        push_exp(0);
        wr(4'h8, 5);
        edges(3 * PER);
        expect_reg("R6 count unchanged", 4'h8, 0);
        expect_reg("R6 done held", 4'hC, 1);
        close_burst("R6 ignored");

        wr(4'hC, 32'h1);
        expect_reg("R5 w1c clears", 4'hC, 0);

        // R7 zero count
        push_exp(0);
        wr(4'h8, 0);
        expect_reg("R7 done next cycle", 4'hC, 1);
        check_eq("R7 dclk low", dclk_o, 0);
        edges(PER);
        close_burst("R7 no pulses");
        wr(4'hC, 32'h1);

        // R8 remaining count
        push_exp(5);
        wr(4'h8, 5);
        expect_reg("R8 loaded", 4'h8, 5);
        edges(2 * PER);
        expect_reg("R8 after two", 4'h8, 3);
        edges(3 * PER - 1);
        expect_reg("R8 not early", 4'hC, 0);
        edges(1);
        expect_reg("R4 done after 5", 4'hC, 1);
        close_burst("R2 burst5");
        wr(4'hC, 32'h1);

        // R9 reload during a low phase
        push_exp(3);
        wr(4'h8, 3);
        edges(5);
        wr(4'h8, 2);
        expect_reg("R9 no done", 4'hC, 0);
        expect_reg("R9 reloaded", 4'h8, 2);
        edges(2 * PER - 1);
        expect_reg("R9 not early", 4'hC, 0);
        edges(1);
        expect_reg("R9 done", 4'hC, 1);
        close_burst("R9 reload");
        wr(4'hC, 32'h1);

        // R10 reload on the completion edge
        push_exp(3);
        wr(4'h8, 1);
        edges(PER - 1);
        wr(4'h8, 2);
        expect_reg("R10 done stays clear", 4'hC, 0);
        expect_reg("R10 new count", 4'h8, 2);
        edges(2 * PER - 1);
        expect_reg("R10 not early", 4'hC, 0);
        edges(1);
        expect_reg("R10 done", 4'hC, 1);
        close_burst("R10 collide");
        wr(4'hC, 32'h1);

        // R11 other offsets
        push_exp(0);
        wr(4'h4, 3);
        wr(4'h0, 32'h1);
        edges(3 * PER);
        expect_reg("R11 read 0x4", 4'h4, 0);
        expect_reg("R11 read 0x0", 4'h0, 0);
        expect_reg("R11 count", 4'h8, 0);
        expect_reg("R11 status", 4'hC, 0);
        close_burst("R11 no pulses");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule